// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device side of a serial flash that answers sequential main-array reads on a four-wire serial bus: an active-low select, a serial clock, a serial data input and a serial data output. It runs on the serial clock and handles both idle clock levels (SPI mode 0 and mode 3). While select is low it takes in one opcode byte and three address bytes. Then it waits for the dummy bytes that the opcode calls for, and after that it sends array bytes MSB first, one bit per clock, for as long as the host keeps clocking. An internal pointer moves on after every byte. It passes from the end of a page to the start of the next page with no gap, and from the end of the last page back to page 0.

Two read opcodes are served: 0xE8 takes four dummy bytes and 0x1B takes two. The address is read either as page plus byte in a 528-byte page layout, or as page plus byte in a 512-byte page layout, as chosen by a static mode input. The storage is a small register array with `PAGES` pages of 528 bytes each. A test harness fills it through a load port while select is high. Any other opcode is ignored: the output stays off until select rises, and the array is not changed.

Top module: `spi_flash_cread`

## Requirements
- R1: After reset and whenever cs_ni is high, so_oe_o is 0.
- R2: Opcode 0xE8 is followed by 24 address bits and 32 dummy bits. so_oe_o stays 0 through all of them and is 1 from the SCK falling edge after the 64th rising edge onwards.
- R3: Opcode 0x1B is followed by 24 address bits and 16 dummy bits. The first data bit is driven on the falling edge after the 48th rising edge.
- R4: With binary_mode_i=0, address bits [21:10] are the page and bits [9:0] are the start byte. Only the low log2(PAGES) bits of the page field are used, and byte b of page p is storage index p*528+b.
- R5: With binary_mode_i=1, address bits [20:9] are the page (low log2(PAGES) bits used) and bits [8:0] are the start byte, at storage index p*528+b.
- R6: Each byte is sent MSB first, one bit per SCK cycle. SI is sampled on the rising edge, and so_o changes only on the falling edge, so the host reads it at the next rising edge.
- R7: After the last byte of a page (527 in 528-byte mode, 511 in 512-byte mode), the next byte is byte 0 of the next page, with no extra clocks.
- R8: After the last byte of page PAGES-1, the next byte is byte 0 of page 0, with no extra clocks.
- R9: With binary_mode_i=0, a start byte field of 528 to 1023 starts at that value minus 528.
- R10: A rising edge on cs_ni ends the read at once, at any bit, and sets so_oe_o to 0. The next command is decoded from a fresh bit count.
- R11: Mode 3 (SCK idle high, with a falling edge before the first rising edge) gives the same bit count and data as mode 0.
- R12: Any opcode other than 0xE8 or 0x1B keeps so_oe_o at 0 until cs_ni rises and leaves the array unchanged.
- R13: While cs_ni is high and ld_en_i is 1, an SCK rising edge writes ld_data_i to storage index ld_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| binary_mode_i | input | 1 | 1 = 512-byte page address layout, 0 = 528-byte layout |
| ld_en_i | input | 1 | Preload write enable (used only while cs_ni is high) |
| ld_addr_i | input | AW | Preload storage index |
| ld_data_i | input | 8 | Preload byte |
| so_o | output | 1 | Serial data out (0 when not driven) |
| so_oe_o | output | 1 | Output enable; 0 means high impedance |

## Verification
A wrong phase counter shows up as the first data bit arriving one or more clocks early or late. That shifts every byte that follows, so the first byte compare already fails. A wrong page or byte pointer gives a wrong byte at the first value or at the first page or array crossing. The bench starts reads two to three bytes before a crossing, so the error is seen within a few bytes. A missed select reset or a failed ignore leaves so_oe_o high, which is checked one time step after select rises and on every bit of an ignored command.

// File: rtl/spi_flash_cread_pkg.sv
`timescale 1ns/1ps
package spi_flash_cread_pkg;
  typedef enum logic [2:0] {
    PH_OP  = 3'd0,
    PH_ADR = 3'd1,
    PH_DUM = 3'd2,
    PH_DAT = 3'd3,
    PH_IGN = 3'd4
  } phase_e;
endpackage

// File: rtl/sfc_cmd_ctrl.sv
`timescale 1ns/1ps
module sfc_cmd_ctrl
  import spi_flash_cread_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int STD_PAGE   = 528,
  parameter int BIN_PAGE   = 512,
  parameter int ADDR_BYTES = 3,
  parameter int DUM_LEGACY = 4,
  parameter int DUM_FAST   = 2,
  parameter logic [7:0] OP_LEGACY = 8'hE8,
  parameter logic [7:0] OP_FAST   = 8'h1B,
  parameter int PW  = $clog2(PAGES),
  parameter int BW  = $clog2(STD_PAGE)
) (
  input  logic          sck_i,
  input  logic          sess_rst_ni,
  input  logic          si_i,
  input  logic          binary_mode_i,
  output phase_e        phase_o,
  output logic [2:0]    bit_idx_o,
  output logic [PW-1:0] page_o,
  output logic [BW-1:0] byte_o
);
  localparam int BBW  = $clog2(BIN_PAGE);
  localparam int SW   = (BW + PW > 8) ? BW + PW : 8;
  localparam int DMAX = (DUM_LEGACY > DUM_FAST) ? DUM_LEGACY : DUM_FAST;
  localparam int CMAX = (DMAX > ADDR_BYTES) ? DMAX : ADDR_BYTES;
  localparam int CW   = $clog2(8 * CMAX);
  localparam logic [BW-1:0] STD_LAST = BW'(STD_PAGE - 1);
  localparam logic [BW-1:0] BIN_LAST = BW'(BIN_PAGE - 1);
  localparam logic [BW-1:0] STD_SZ   = BW'(STD_PAGE);
  localparam logic [PW-1:0] PG_LAST  = PW'(PAGES - 1);

  phase_e        phase;
  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q, dum_last_q;
  logic [2:0]    bidx_q;
  logic [PW-1:0] page_q;
  logic [BW-1:0] byte_q;

  logic [SW-1:0] word_w;
  logic [PW-1:0] page_d;
  logic [BW-1:0] byte_d, byte_last;

  assign word_w    = {sh_q[SW-2:0], si_i};
  assign byte_last = binary_mode_i ? BIN_LAST : STD_LAST;

  // address decode from the low bits left in the shifter after 24 bits
  always_comb begin
    if (binary_mode_i) begin
      page_d = word_w[BBW+PW-1:BBW];
      byte_d = BW'(word_w[BBW-1:0]);
    end else begin
      page_d = word_w[BW+PW-1:BW];
      byte_d = word_w[BW-1:0];
      if (byte_d >= STD_SZ) byte_d = byte_d - STD_SZ;
    end
  end

  always_ff @(posedge sck_i or negedge sess_rst_ni) begin
    if (!sess_rst_ni) begin
      phase      <= PH_OP;
      sh_q       <= '0;
      cnt_q      <= '0;
      dum_last_q <= '0;
      bidx_q     <= '0;
      page_q     <= '0;
      byte_q     <= '0;
    end else begin
      case (phase)
        PH_OP: begin
          sh_q <= word_w;
          if (cnt_q == CW'(7)) begin
            cnt_q <= '0;
            if (word_w[7:0] == OP_LEGACY) begin
              phase      <= PH_ADR;
              dum_last_q <= CW'(8 * DUM_LEGACY - 1);
            end else if (word_w[7:0] == OP_FAST) begin
              phase      <= PH_ADR;
              dum_last_q <= CW'(8 * DUM_FAST - 1);
            end else begin
              phase <= PH_IGN;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ADR: begin
          sh_q <= word_w;
          if (cnt_q == CW'(8 * ADDR_BYTES - 1)) begin
            cnt_q  <= '0;
            page_q <= page_d;
            byte_q <= byte_d;
            phase  <= PH_DUM;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DUM: begin
          if (cnt_q == dum_last_q) begin
            phase  <= PH_DAT;
            bidx_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DAT: begin
          bidx_q <= bidx_q + 1'b1;
          if (bidx_q == 3'd7) begin
            if (byte_q == byte_last) begin
              byte_q <= '0;
              page_q <= (page_q == PG_LAST) ? '0 : page_q + 1'b1;
            end else begin
              byte_q <= byte_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign phase_o   = phase;
  assign bit_idx_o = bidx_q;
  assign page_o    = page_q;
  assign byte_o    = byte_q;
endmodule

// File: rtl/sfc_array.sv
`timescale 1ns/1ps
module sfc_array #(
  parameter int PAGES    = 4,
  parameter int STD_PAGE = 528,
  parameter int PW       = $clog2(PAGES),
  parameter int BW       = $clog2(STD_PAGE),
  parameter int ARR      = PAGES * STD_PAGE,
  parameter int AW       = $clog2(ARR)
) (
  input  logic          sck_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i,
  input  logic [PW-1:0] page_i,
  input  logic [BW-1:0] byte_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0]    mem_q [ARR];
  logic [AW-1:0] rd_idx;

  assign rd_idx = AW'(page_i) * AW'(STD_PAGE) + AW'(byte_i);

  always_ff @(posedge sck_i) begin
    if (ld_we_i && (ld_addr_i < AW'(ARR))) mem_q[ld_addr_i] <= ld_data_i;
  end

  assign rd_data_o = (rd_idx < AW'(ARR)) ? mem_q[rd_idx] : 8'h00;
endmodule

// File: rtl/sfc_so_drv.sv
`timescale 1ns/1ps
module sfc_so_drv
  import spi_flash_cread_pkg::*;
(
  input  logic       sck_i,
  input  logic       sess_rst_ni,
  input  phase_e     phase_i,
  input  logic [2:0] bit_idx_i,
  input  logic [7:0] byte_i,
  output logic       so_o,
  output logic       oe_o
);
  logic drv_q, bit_q;

  // launch on falling edge; bit 7 first (~idx == 7 - idx)
  always_ff @(negedge sck_i or negedge sess_rst_ni) begin
    if (!sess_rst_ni) begin
      drv_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      drv_q <= (phase_i == PH_DAT);
      bit_q <= byte_i[~bit_idx_i];
    end
  end

  assign oe_o = drv_q;
  assign so_o = drv_q & bit_q;
endmodule

// File: rtl/spi_flash_cread.sv
`timescale 1ns/1ps
module spi_flash_cread
  import spi_flash_cread_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int STD_PAGE   = 528,
  parameter int BIN_PAGE   = 512,
  parameter int ADDR_BYTES = 3,
  parameter int DUM_LEGACY = 4,
  parameter int DUM_FAST   = 2,
  parameter logic [7:0] OP_LEGACY = 8'hE8,
  parameter logic [7:0] OP_FAST   = 8'h1B,
  localparam int AW = $clog2(PAGES * STD_PAGE)
) (
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          si_i,
  input  logic          binary_mode_i,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int PW = $clog2(PAGES);
  localparam int BW = $clog2(STD_PAGE);

  logic          sess_rst_n;
  logic          ld_we;
  phase_e        phase;
  logic [2:0]    bit_idx;
  logic [PW-1:0] page_q;
  logic [BW-1:0] byte_q;
  logic [7:0]    rd_byte;

  // select high holds the whole session in reset
  assign sess_rst_n = rst_ni & ~cs_ni;
  assign ld_we      = rst_ni & cs_ni & ld_en_i;

  sfc_cmd_ctrl #(
    .PAGES(PAGES), .STD_PAGE(STD_PAGE), .BIN_PAGE(BIN_PAGE),
    .ADDR_BYTES(ADDR_BYTES), .DUM_LEGACY(DUM_LEGACY), .DUM_FAST(DUM_FAST),
    .OP_LEGACY(OP_LEGACY), .OP_FAST(OP_FAST), .PW(PW), .BW(BW)
  ) u_ctrl (
    .sck_i(sck_i), .sess_rst_ni(sess_rst_n), .si_i(si_i),
    .binary_mode_i(binary_mode_i), .phase_o(phase), .bit_idx_o(bit_idx),
    .page_o(page_q), .byte_o(byte_q)
  );

  sfc_array #(
    .PAGES(PAGES), .STD_PAGE(STD_PAGE), .PW(PW), .BW(BW),
    .ARR(PAGES * STD_PAGE), .AW(AW)
  ) u_array (
    .sck_i(sck_i), .ld_we_i(ld_we), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .page_i(page_q), .byte_i(byte_q),
    .rd_data_o(rd_byte)
  );

  sfc_so_drv u_so (
    .sck_i(sck_i), .sess_rst_ni(sess_rst_n), .phase_i(phase),
    .bit_idx_i(bit_idx), .byte_i(rd_byte), .so_o(so_o), .oe_o(so_oe_o)
  );
endmodule

// File: rtl/sfc_chk.sv
`timescale 1ns/1ps
module sfc_chk
  import spi_flash_cread_pkg::*;
#(
  parameter int PAGES    = 4,
  parameter int STD_PAGE = 528,
  parameter int BIN_PAGE = 512,
  parameter int PW       = $clog2(PAGES),
  parameter int BW       = $clog2(STD_PAGE)
) (
  input logic          sck_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          so_oe_o,
  input logic          binary_mode_i,
  input phase_e        phase,
  input logic [2:0]    bit_idx,
  input logic [PW-1:0] page,
  input logic [BW-1:0] byte_ix
);
  localparam logic [BW-1:0] STD_LAST = BW'(STD_PAGE - 1);
  localparam logic [BW-1:0] BIN_LAST = BW'(BIN_PAGE - 1);
  localparam logic [PW-1:0] PG_LAST  = PW'(PAGES - 1);

  logic [BW-1:0] last;
  assign last = binary_mode_i ? BIN_LAST : STD_LAST;

  // R1
  idle_quiet_chk: assert property (@(posedge sck_i) disable iff (!rst_ni)
    cs_ni |-> !so_oe_o);

  // R12
  ignore_quiet_chk: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_IGN) |-> !so_oe_o);

  // R2
  oe_in_data_chk: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    so_oe_o |-> (phase == PH_DAT));

  // R9
  byte_bound_chk: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_DAT) |-> (byte_ix <= last));

  // R7
  page_roll_chk: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_DAT && bit_idx == 3'd7 && byte_ix == last && page != PG_LAST)
    |=> (byte_ix == '0 && page == $past(page) + PW'(1)));

  // R8
  array_wrap_chk: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_DAT && bit_idx == 3'd7 && byte_ix == last && page == PG_LAST)
    |=> (byte_ix == '0 && page == '0));
endmodule

bind spi_flash_cread sfc_chk #(
  .PAGES(PAGES), .STD_PAGE(STD_PAGE), .BIN_PAGE(BIN_PAGE), .PW(PW), .BW(BW)
) u_chk (
  .sck_i(sck_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .so_oe_o(so_oe_o),
  .binary_mode_i(binary_mode_i), .phase(phase), .bit_idx(bit_idx),
  .page(page_q), .byte_ix(byte_q)
);

// File: tb/spi_flash_cread_tb.sv
`timescale 1ns/1ps
module spi_flash_cread_tb;
  localparam int PAGES = 4;
  localparam int PSZ   = 528;
  localparam int ARR   = PAGES * PSZ;
  localparam int AW    = $clog2(ARR);
  localparam int H     = 10;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, bin_mode, ld_en;
  logic [AW-1:0] ld_addr;
  logic [7:0] ld_data;
  logic so, so_oe;
  logic [7:0] mem [ARR];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_flash_cread u_dut (
    .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .binary_mode_i(bin_mode), .ld_en_i(ld_en), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  function automatic logic [23:0] mk_std(input int pg, input int by);
    return {2'b00, 12'(pg), 10'(by)};
  endfunction

  function automatic logic [23:0] mk_bin(input int pg, input int by);
    return {3'b000, 12'(pg), 9'(by)};
  endfunction

  task automatic load(input int idx, input logic [7:0] d);
    ld_en = 1'b1; ld_addr = AW'(idx); ld_data = d; mem[idx] = d;
    #(H/2); sck = 1'b1; #(H/2); sck = 1'b0;
    ld_en = 1'b0;
  endtask

  // one SCK cycle; SO sampled mid low phase, before the rising edge
  task automatic bit_cycle(input bit m3, input logic d, output logic s, output logic e);
    if (m3) sck = 1'b0;
    si = d;
    #(H/2); s = so; e = so_oe;
    #(H/2); sck = 1'b1;
    #H;
    if (!m3) sck = 1'b0;
  endtask

  task automatic do_read(input bit m3, input bit bin, input logic [7:0] op,
                         input logic [23:0] a, input int nbytes, input int tail,
                         input string tag);
    int pg, by, ndum, last;
    logic s, e, oe_all;
    bit hdr_oe;
    logic [7:0] got;
    bin_mode = bin;
    sck = m3;
    #H; cs_n = 1'b0; #H;
    hdr_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin bit_cycle(m3, op[i], s, e); hdr_oe |= e; end
    for (int i = 23; i >= 0; i--) begin bit_cycle(m3, a[i], s, e); hdr_oe |= e; end
    ndum = (op == 8'hE8) ? 32 : (op == 8'h1B) ? 16 : 64;
    for (int i = 0; i < ndum; i++) begin bit_cycle(m3, 1'($urandom), s, e); hdr_oe |= e; end
    chk(!hdr_oe, {tag, " output off before data"}, int'(hdr_oe), 0);
    if (bin) begin pg = int'(a[20:9]) % PAGES; by = int'(a[8:0]); last = 511; end
    else begin
      pg = int'(a[21:10]) % PAGES; by = int'(a[9:0]);
      if (by >= PSZ) by -= PSZ;
      last = PSZ - 1;
    end
    for (int b = 0; b < nbytes; b++) begin
      got = '0; oe_all = 1'b1;
      for (int i = 0; i < 8; i++) begin
        bit_cycle(m3, 1'($urandom), s, e);
        got = {got[6:0], s}; oe_all &= e;
      end
      chk(oe_all, {tag, " output driven"}, int'(oe_all), 1);
      chk(got == mem[pg * PSZ + by], {tag, " data byte"}, int'(got), int'(mem[pg * PSZ + by]));
      if (by == last) begin by = 0; pg = (pg + 1) % PAGES; end
      else by++;
    end
    for (int i = 0; i < tail; i++) bit_cycle(m3, 1'b0, s, e);
    cs_n = 1'b1;
    #1;
    chk(so_oe == 1'b0, {tag, " R10 off after select rise"}, int'(so_oe), 0);
    #H;
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; bin_mode = 1'b0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    #20;
    chk(so_oe == 1'b0, "R1 reset", int'(so_oe), 0);
    rst_n = 1'b1;
    #20;
    chk(so_oe == 1'b0, "R1 idle", int'(so_oe), 0);

    // R13 preload through the load port
    for (int i = 0; i < ARR; i++) load(i, 8'($urandom));
    load(2 * PSZ + 5, 8'hA5);
    do_read(1'b0, 1'b0, 8'hE8, mk_std(2, 5), 1, 0, "R13");

    do_read(1'b0, 1'b0, 8'hE8, mk_std(1, 100), 4, 0, "R2 R4 R6");
    do_read(1'b0, 1'b0, 8'hE8, mk_std(6, 17), 2, 0, "R4 page field modulo");
    do_read(1'b0, 1'b0, 8'h1B, mk_std(3, 0), 3, 0, "R3");
    do_read(1'b0, 1'b1, 8'hE8, mk_bin(1, 300), 3, 0, "R5");
    do_read(1'b0, 1'b1, 8'h1B, mk_bin(2, 7), 2, 0, "R5 R3");
    do_read(1'b0, 1'b0, 8'hE8, mk_std(1, 525), 5, 0, "R7 std");
    do_read(1'b0, 1'b1, 8'h1B, mk_bin(0, 509), 4, 0, "R7 bin");
    do_read(1'b0, 1'b0, 8'h1B, mk_std(3, 526), 4, 0, "R8 std");
    do_read(1'b0, 1'b1, 8'hE8, mk_bin(3, 510), 4, 0, "R8 bin");
    do_read(1'b0, 1'b0, 8'hE8, mk_std(0, 600), 2, 0, "R9 600");
    do_read(1'b0, 1'b0, 8'h1B, mk_std(2, 1023), 2, 0, "R9 1023");
    do_read(1'b0, 1'b0, 8'hE8, mk_std(1, 40), 1, 3, "R10 mid-byte");
    do_read(1'b0, 1'b0, 8'h1B, mk_std(1, 41), 2, 0, "R10 fresh");
    do_read(1'b1, 1'b0, 8'hE8, mk_std(2, 200), 3, 0, "R11 E8");
    do_read(1'b1, 1'b1, 8'h1B, mk_bin(3, 511), 3, 0, "R11 1B");

    // R12 other opcodes: output stays off, array untouched
    do_read(1'b0, 1'b0, 8'h82, mk_std(0, 0), 0, 0, "R12 op82");
    do_read(1'b1, 1'b0, 8'hD2, mk_std(0, 0), 0, 0, "R12 opD2");
    do_read(1'b0, 1'b0, 8'hE8, mk_std(0, 0), 4, 0, "R12 array unchanged");

    // R6 constrained random reads
    for (int t = 0; t < 24; t++) begin
      do_read(1'($urandom), 1'($urandom), ($urandom % 2) ? 8'hE8 : 8'h1B,
              24'($urandom), 1 + int'($urandom % 6), 0, "R6 random");
    end

    summary();
  end
endmodule